// File: doc/BRIEF.md
# FEAC Codeword Receiver

This block watches the serial far-end alarm and control channel, one bit per `bit_en` strobe, and picks out the repeating 16-bit codewords sent on it. A codeword is received least significant bit first. The first byte is all ones. The second byte holds a zero, then six payload bits, then another zero. The same payload must show up in `CONFIRM` back-to-back codeword periods before it counts as valid. A valid payload is queued in a small receive FIFO. A run of sixteen ones after a valid codeword is reported as the idle condition.

The status side offers a set of outputs. Three latched event flags report a new codeword, idle and FIFO overflow, and all three clear on a read strobe. The status side also provides a live FIFO-empty flag, the head entry of the FIFO, and an interrupt line gated by mask inputs. The same read strobe that clears the events also pops one FIFO entry.

Top module: `feac_rx`

## Requirements
- R1: A codeword is recognised when the 16 most recent bits, in arrival order, are eight ones, a zero, six payload bits and a zero. The first-arriving payload bit becomes `fifo_data[0]` and the last-arriving becomes `fifo_data[5]`.
- R2: A payload is validated only when it matches in `CONFIRM` consecutive codeword periods, each exactly 16 bits after the previous match. `CONFIRM` defaults to 10.
- R3: Once a payload has been validated, further repeats of the same payload do not validate it again. Only a different payload, or an idle condition in between, allows a new validation.
- R4: The receive FIFO holds `DEPTH` entries, 4 by default. `fifo_data` shows the oldest entry. A read strobe (`rd_stb`) pops that entry. `fifo_empty` is high exactly when the FIFO holds nothing, and `fifo_data` is zero while it is high.
- R5: `ev_code` goes high in the cycle after each validation. It stays high until the clock edge that follows a read strobe.
- R6: `ev_idle` goes high in the cycle after the 16th consecutive one that follows a validated codeword. It fires once per idle run and clears on a read strobe.
- R7: If a validation occurs while the FIFO is full, that payload is dropped, the FIFO contents are left unchanged, and `ev_ovf` is set. `ev_ovf` clears on a read strobe. The full check uses the FIFO state before any pop in the same cycle.
- R8: `irq` is high when `feac_mask` is high and either `ev_code` is set, or `ev_idle` is set with `idle_ie` high. `ev_ovf` has no effect on `irq`.
- R9: If an event and a read strobe fall in the same cycle, the event flag is left set.
- R10: After reset, all event flags are low, the FIFO is empty, `fifo_data` is zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Strobe marking a valid serial bit |
| bit_in | input | 1 | Serial channel bit |
| rd_stb | input | 1 | Status read: clears events, pops FIFO |
| feac_mask | input | 1 | Global interrupt enable |
| idle_ie | input | 1 | Idle interrupt enable |
| ev_code | output | 1 | Latched new-codeword event |
| ev_idle | output | 1 | Latched idle event |
| ev_ovf | output | 1 | Latched FIFO overflow event |
| fifo_empty | output | 1 | Live FIFO-empty flag |
| fifo_data | output | 6 | Head FIFO payload |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives all 64 payloads through the receiver, each sent as three copies with `CONFIRM` set to 3. It checks that nothing is flagged after two copies and that the exact payload is flagged after the third, which separates the debounce count and the bit order. Repeats of an already validated payload check that no second FIFO entry appears. A run of sixteen ones, compared with a run of fifteen, pins down the idle threshold and shows that the payload can be validated again afterwards. Filling the FIFO and then sending more payloads separates dropping from overwriting. A read that coincides with a validation, and the mask inputs toggled while events are held, check the clear and interrupt rules.

// File: rtl/feac_rx.sv
module feac_rx #(
  parameter int CONFIRM = 10,
  parameter int DEPTH   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  input  logic       rd_stb,
  input  logic       feac_mask,
  input  logic       idle_ie,
  output logic       ev_code,
  output logic       ev_idle,
  output logic       ev_ovf,
  output logic       fifo_empty,
  output logic [5:0] fifo_data,
  output logic       irq
);
  localparam int CW = $clog2(CONFIRM + 1);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);

  logic [15:0]   sr;
  logic [4:0]    gap, ones;
  logic [5:0]    cand, lastp;
  logic [CW-1:0] cnt;
  logic          lv;
  logic [5:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [NW-1:0] n;

  wire [15:0] nsr   = {bit_in, sr[15:1]};
  wire        hit   = bit_en && nsr[7:0] == 8'hFF && !nsr[8] && !nsr[15];
  wire [5:0]  pay   = nsr[14:9];
  wire        same  = hit && cnt != '0 && pay == cand && gap == 5'd15;
  wire [CW-1:0] cnt_n = !same ? CW'(1) : (cnt == CW'(CONFIRM)) ? cnt : cnt + 1'b1;
  wire        valid = hit && cnt_n == CW'(CONFIRM) && (!lv || pay != lastp);
  wire        idle  = bit_en && bit_in && ones == 5'd15 && lv;
  wire        full  = n == NW'(DEPTH);
  wire        push  = valid && !full;
  wire        pop   = rd_stb && n != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0; gap <= '0; ones <= '0; cand <= '0; lastp <= '0; cnt <= '0; lv <= 1'b0;
    end else if (bit_en) begin
      sr   <= nsr;
      gap  <= hit ? 5'd0 : (gap == 5'd31 ? gap : gap + 5'd1);
      ones <= !bit_in ? 5'd0 : (ones == 5'd16 ? ones : ones + 5'd1);
      if (hit) begin
        cand <= pay;
        cnt  <= cnt_n;
      end
      if (valid) begin
        lv    <= 1'b1;
        lastp <= pay;
      end else if (idle) begin
        lv  <= 1'b0;
        cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; n <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      n <= n + NW'(push) - NW'(pop);
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= pay;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_code <= 1'b0; ev_idle <= 1'b0; ev_ovf <= 1'b0;
    end else begin
      ev_code <= valid | (ev_code & ~rd_stb);
      ev_idle <= idle | (ev_idle & ~rd_stb);
      ev_ovf  <= (valid & full) | (ev_ovf & ~rd_stb);
    end
  end

  assign fifo_empty = n == '0;
  assign fifo_data  = fifo_empty ? 6'd0 : mem[rp];
  assign irq        = feac_mask & (ev_code | (idle_ie & ev_idle));
endmodule

module feac_rx_chk #(
  parameter int DEPTH = 4,
  parameter int NW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          rd_stb,
  input logic          feac_mask,
  input logic          ev_code,
  input logic          ev_idle,
  input logic          ev_ovf,
  input logic          fifo_empty,
  input logic [5:0]    fifo_data,
  input logic          irq,
  input logic [NW-1:0] n
);
  a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> fifo_data == 6'd0);
  a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
    n <= NW'(DEPTH));
  a_r5_set_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> !$rose(ev_code) && !$rose(ev_idle));
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !bit_en |=> !ev_code && !ev_idle && !ev_ovf);
  a_r7_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_ovf) |-> !fifo_empty);
  a_r8_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !feac_mask |-> !irq);
  a_r8_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ev_code || ev_idle);
endmodule

bind feac_rx feac_rx_chk #(.DEPTH(DEPTH), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rd_stb(rd_stb), .feac_mask(feac_mask),
  .ev_code(ev_code), .ev_idle(ev_idle), .ev_ovf(ev_ovf), .fifo_empty(fifo_empty),
  .fifo_data(fifo_data), .irq(irq), .n(n)
);

// File: tb/sim_feac_rx.sv
module sim_feac_rx;
  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0, rd_stb = 1'b0;
  logic feac_mask = 1'b1, idle_ie = 1'b0;
  logic ev_code, ev_idle, ev_ovf, fifo_empty, irq;
  logic [5:0] fifo_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  feac_rx #(.CONFIRM(3), .DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .rd_stb(rd_stb),
    .feac_mask(feac_mask), .idle_ie(idle_ie), .ev_code(ev_code), .ev_idle(ev_idle),
    .ev_ovf(ev_ovf), .fifo_empty(fifo_empty), .fifo_data(fifo_data), .irq(irq)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic send_bit(logic b, logic rd = 1'b0);
    @(negedge clk);
    bit_en = 1'b1; bit_in = b; rd_stb = rd;
    @(negedge clk);
    bit_en = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic send_code(logic [5:0] p, logic rd_last = 1'b0);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(p[i]);
    send_bit(1'b0, rd_last);
  endtask

  task automatic read();
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic validate(logic [5:0] p);
    for (int k = 0; k < 3; k++) send_code(p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ev_code", ev_code, 0);
    chk("R10 ev_idle", ev_idle, 0);
    chk("R10 ev_ovf", ev_ovf, 0);
    chk("R10 empty", fifo_empty, 1);
    chk("R10 data", fifo_data, 0);
    chk("R10 irq", irq, 0);

    send_code(6'h2D); send_code(6'h2D);
    chk("R2 no event after two", ev_code, 0);
    send_code(6'h2D);
    chk("R2 event after three", ev_code, 1);
    chk("R1 data", fifo_data, 6'h2D);
    chk("R8 irq code", irq, 1);
    send_code(6'h2D); send_code(6'h2D); send_code(6'h2D);
    read();
    chk("R5 cleared", ev_code, 0);
    chk("R3 single entry", fifo_empty, 1);

    for (int p = 0; p < 64; p++) begin
      send_code(6'(p)); send_code(6'(p));
      chk("R2 sweep early", ev_code, 0);
      chk("R4 sweep empty", fifo_empty, 1);
      send_code(6'(p));
      chk("R5 sweep event", ev_code, 1);
      chk("R1 sweep data", fifo_data, p);
      read();
      chk("R5 sweep clear", ev_code, 0);
      chk("R4 sweep pop", fifo_empty, 1);
    end

    for (int i = 0; i < 15; i++) send_bit(1'b1);
    chk("R6 fifteen ones", ev_idle, 0);
    send_bit(1'b1);
    chk("R6 sixteen ones", ev_idle, 1);
    chk("R8 idle masked", irq, 0);
    idle_ie = 1'b1; #1;
    chk("R8 idle irq", irq, 1);
    for (int i = 0; i < 20; i++) send_bit(1'b1);
    read();
    chk("R6 idle cleared", ev_idle, 0);
    chk("R8 irq cleared", irq, 0);
    validate(6'd63);
    chk("R3 revalidate after idle", ev_code, 1);
    chk("R3 data", fifo_data, 63);
    read();

    validate(6'd1); validate(6'd2); validate(6'd3); validate(6'd4);
    chk("R7 no ovf yet", ev_ovf, 0);
    validate(6'd5);
    chk("R7 ovf set", ev_ovf, 1);
    chk("R8 ovf no irq effect", irq, 1);
    chk("R7 head kept", fifo_data, 1);
    read();
    chk("R7 ovf cleared", ev_ovf, 0);
    chk("R4 next head", fifo_data, 2);
    validate(6'd6);
    chk("R7 room again", ev_ovf, 0);
    validate(6'd7);
    chk("R7 ovf again", ev_ovf, 1);
    for (int e = 2; e < 7; e++) begin
      if (e == 5) continue;
      chk("R4 drain order", fifo_data, e);
      read();
    end
    chk("R4 drained", fifo_empty, 1);
    chk("R7 ovf read clear", ev_ovf, 0);

    send_code(6'd9); send_code(6'd9); send_code(6'd9, 1'b1);
    chk("R9 event kept", ev_code, 1);
    chk("R9 data", fifo_data, 9);
    feac_mask = 1'b0; #1;
    chk("R8 global mask", irq, 0);
    feac_mask = 1'b1; #1;
    chk("R8 unmasked", irq, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule